// File: doc/BRIEF.md
# Clock Output Stop Gating

This block sits between a set of free-running clock sources and the output drivers of a clock generator. It turns each source into either a differential output (true and complement) for the processor and serial-link groups, or a single-ended output for the parallel-bus group. For every output it decides, each cycle, whether the output runs, is parked in a defined stopped level, or is disabled.

All sources, including the clock levels themselves, are sampled on one fast system clock `clk`. Each source level arrives as a plain input that changes at a much lower rate than `clk`. The inputs that control gating are:

- two active-low stop inputs, one for the processor group and one for the bus group;
- two active-low clock-request inputs, each of which can be routed to one of two serial-link outputs;
- static configuration bits for output enables, stop enables, free-running selection and request routing.

The stop and request pins are asynchronous and pass through a synchronizer first. A run/stop change is taken up only at a falling edge of the affected output's own source. As a result, no high or low phase on any output is ever shorter than half a source period.

Top module: `clk_stop_gate`

## Requirements
- R1: An output whose enable bit is 0 is disabled whatever the stop and request inputs are. A disabled differential pair drives true 0 and complement 0, and a disabled single-ended output drives 0. This takes effect on the clock edge after the enable is sampled.
- R2: While `cpu_stop_n` is low, each processor pair whose `cpu_stop_en` bit is 1 parks with true 1 and complement 0. A processor pair whose `cpu_stop_en` bit is 0 keeps toggling.
- R3: While `pci_stop_n` is low, the stoppable bus outputs (indices 0 and 1, which have a 0 in `PCI_FREE_MASK`) are held at 0. The free-running bus output (index 2) keeps toggling unless `pcif_stop_en` is 1, in which case it is held at 0 as well.
- R4: Serial-link outputs stop with `pci_stop_n` low only when `src_stop_ctl` is 1. When `src_stop_ctl` is 0 they keep running. A stopped serial-link pair parks with true 1 and complement 0.
- R5: When `cr_a_en` is 1, request A is routed to serial-link output 0 if `cr_a_sel` is 0, or to output 2 if `cr_a_sel` is 1. The routed output runs while `cr_a_n` is low and parks while it is high. Unrouted outputs, and all outputs when `cr_a_en` is 0, ignore `cr_a_n`.
- R6: Request C behaves the same way through `cr_c_en`, `cr_c_sel` and `cr_c_n`, with the same targets: 0 when the select is 0, and 2 when the select is 1.
- R7: A run/stop change of an output happens only on a falling edge of its own source. So no high or low level on a running or stopping output lasts fewer `clk` cycles than its source's half period.
- R8: When several stop conditions apply to one output, any one of them parks it. A disabled output stays disabled even when a stop condition applies.
- R9: A running output follows its source one `clk` cycle late: true equals the source level sampled at the previous edge, and complement is its inverse. A pair never drives true and complement both high.
- R10: While `rst_n` is low, every output drives 0. After reset every enabled output runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ph | input | N_CPU | Free-running source levels for the processor pairs |
| src_ph | input | N_SRC | Free-running source levels for the serial-link pairs |
| pci_ph | input | N_PCI | Free-running source levels for the bus outputs |
| cpu_stop_n | input | 1 | Asynchronous active-low processor stop |
| pci_stop_n | input | 1 | Asynchronous active-low bus stop |
| cr_a_n | input | 1 | Asynchronous active-low clock request A |
| cr_c_n | input | 1 | Asynchronous active-low clock request C |
| cpu_oe | input | N_CPU | Processor pair enables |
| src_oe | input | N_SRC | Serial-link pair enables |
| pci_oe | input | N_PCI | Bus output enables |
| cpu_stop_en | input | N_CPU | Per processor pair: 1 = obeys the processor stop |
| src_stop_ctl | input | 1 | 1 = serial-link pairs obey the bus stop |
| pcif_stop_en | input | 1 | 1 = free-running bus outputs obey the bus stop |
| cr_a_en | input | 1 | Enables routing of request A |
| cr_a_sel | input | 1 | Request A target: 0 = output 0, 1 = output 2 |
| cr_c_en | input | 1 | Enables routing of request C |
| cr_c_sel | input | 1 | Request C target: 0 = output 0, 1 = output 2 |
| cpu_t | output | N_CPU | Processor pair true outputs |
| cpu_c | output | N_CPU | Processor pair complement outputs |
| src_t | output | N_SRC | Serial-link pair true outputs |
| src_c | output | N_SRC | Serial-link pair complement outputs |
| pci_o | output | N_PCI | Single-ended bus outputs |

## Verification
The assertions assume that each source level is a clean clock that is synchronous to `clk` and holds each level for at least two `clk` cycles. Under that assumption a sampled 1-to-0 step is a genuine falling edge. The assertions also assume that enable and routing bits change only while the affected output's glitch behaviour does not matter. The bench meets both assumptions: it drives the source levels as counters on the inactive edge of `clk`, with half periods of 2, 3 and 4 cycles. It also changes only static bits while the runt-width monitor is paused. Stop and request pins, by contrast, are toggled freely at arbitrary cycles, since the synchronizer exists for them.

// File: rtl/cgate_pkg.sv
package cgate_pkg;

  typedef enum logic [1:0] {
    GATE_OFF  = 2'd0,
    GATE_PARK = 2'd1,
    GATE_RUN  = 2'd2
  } gate_mode_e;

  // Disable wins over park, park wins over run (R8).
  function automatic gate_mode_e pick_mode(input logic enabled, input logic running);
    if (!enabled) return GATE_OFF;
    if (!running) return GATE_PARK;
    return GATE_RUN;
  endfunction

  // Differential level as {true, complement}.
  function automatic logic [1:0] diff_level(input gate_mode_e m, input logic ph);
    case (m)
      GATE_RUN:  return {ph, ~ph};
      GATE_PARK: return 2'b10;
      default:   return 2'b00;
    endcase
  endfunction

  function automatic logic se_level(input gate_mode_e m, input logic ph);
    return (m == GATE_RUN) ? ph : 1'b0;
  endfunction

  // True when a raised request line is routed to output idx.
  function automatic logic req_parks(input logic en, input logic sel, input logic req_n,
                                     input int idx, input int tgt0, input int tgt1);
    return en && req_n && (sel ? (idx == tgt1) : (idx == tgt0));
  endfunction

endpackage

// File: rtl/cgate_sync.sv
module cgate_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cgate_cell.sv
module cgate_cell
  import cgate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase,
  input  logic       oe,
  input  logic       want_run,
  output gate_mode_e mode,
  output logic       run,
  output logic       fall
);
  logic ph_q;
  logic run_q;
  logic run_nxt;

  // A falling edge of the source is the only point where run state may move.
  assign fall    = ph_q & ~phase;
  assign run_nxt = fall ? want_run : run_q;
  assign mode    = pick_mode(oe, run_nxt);
  assign run     = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      run_q <= 1'b1;
    end else begin
      ph_q  <= phase;
      run_q <= run_nxt;
    end
  end
endmodule

// File: rtl/cgate_crmap.sv
module cgate_crmap
  import cgate_pkg::*;
#(
  parameter int N_SRC = 5,
  parameter int TGT0  = 0,
  parameter int TGT1  = 2
) (
  input  logic             req_a_n,
  input  logic             req_c_n,
  input  logic             a_en,
  input  logic             a_sel,
  input  logic             c_en,
  input  logic             c_sel,
  output logic [N_SRC-1:0] req_park
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_map
    assign req_park[i] = req_parks(a_en, a_sel, req_a_n, i, TGT0, TGT1)
                       | req_parks(c_en, c_sel, req_c_n, i, TGT0, TGT1);
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import cgate_pkg::*;
#(
  parameter int               N_CPU         = 3,
  parameter int               N_SRC         = 5,
  parameter int               N_PCI         = 3,
  parameter int               SYNC_STAGES   = 2,
  parameter int               REQ_TGT0      = 0,
  parameter int               REQ_TGT1      = 2,
  parameter logic [N_PCI-1:0] PCI_FREE_MASK = 3'b100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CPU-1:0] cpu_ph,
  input  logic [N_SRC-1:0] src_ph,
  input  logic [N_PCI-1:0] pci_ph,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             cr_a_n,
  input  logic             cr_c_n,
  input  logic [N_CPU-1:0] cpu_oe,
  input  logic [N_SRC-1:0] src_oe,
  input  logic [N_PCI-1:0] pci_oe,
  input  logic [N_CPU-1:0] cpu_stop_en,
  input  logic             src_stop_ctl,
  input  logic             pcif_stop_en,
  input  logic             cr_a_en,
  input  logic             cr_a_sel,
  input  logic             cr_c_en,
  input  logic             cr_c_sel,
  output logic [N_CPU-1:0] cpu_t,
  output logic [N_CPU-1:0] cpu_c,
  output logic [N_SRC-1:0] src_t,
  output logic [N_SRC-1:0] src_c,
  output logic [N_PCI-1:0] pci_o
);
  localparam int N_STOP = 2;
  localparam int N_REQ  = 2;

  logic [N_STOP-1:0] stop_s;
  logic [N_REQ-1:0]  req_s;
  logic              cpu_stop_act;
  logic              pci_stop_act;
  logic [N_SRC-1:0]  req_park;

  logic [N_CPU-1:0]  cpu_want, cpu_run, cpu_fall;
  logic [N_SRC-1:0]  src_want, src_run, src_fall;
  logic [N_PCI-1:0]  pci_want, pci_run, pci_fall;

  cgate_sync #(.W(N_STOP), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .d({pci_stop_n, cpu_stop_n}), .q(stop_s)
  );

  cgate_sync #(.W(N_REQ), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d({cr_c_n, cr_a_n}), .q(req_s)
  );

  assign cpu_stop_act = ~stop_s[0];
  assign pci_stop_act = ~stop_s[1];

  cgate_crmap #(.N_SRC(N_SRC), .TGT0(REQ_TGT0), .TGT1(REQ_TGT1)) u_crmap (
    .req_a_n (req_s[0]),
    .req_c_n (req_s[1]),
    .a_en    (cr_a_en),
    .a_sel   (cr_a_sel),
    .c_en    (cr_c_en),
    .c_sel   (cr_c_sel),
    .req_park(req_park)
  );

  // Processor pairs
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    gate_mode_e m;
    logic [1:0] lvl_q;
    assign cpu_want[i] = ~(cpu_stop_act & cpu_stop_en[i]);
    cgate_cell u_cell (
      .clk(clk), .rst_n(rst_n), .phase(cpu_ph[i]), .oe(cpu_oe[i]),
      .want_run(cpu_want[i]), .mode(m), .run(cpu_run[i]), .fall(cpu_fall[i])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 2'b00;
      else        lvl_q <= diff_level(m, cpu_ph[i]);
    end
    assign cpu_t[i] = lvl_q[1];
    assign cpu_c[i] = lvl_q[0];
  end

  // Serial-link pairs
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    gate_mode_e m;
    logic [1:0] lvl_q;
    assign src_want[i] = ~((pci_stop_act & src_stop_ctl) | req_park[i]);
    cgate_cell u_cell (
      .clk(clk), .rst_n(rst_n), .phase(src_ph[i]), .oe(src_oe[i]),
      .want_run(src_want[i]), .mode(m), .run(src_run[i]), .fall(src_fall[i])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 2'b00;
      else        lvl_q <= diff_level(m, src_ph[i]);
    end
    assign src_t[i] = lvl_q[1];
    assign src_c[i] = lvl_q[0];
  end

  // Single-ended bus outputs
  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    gate_mode_e m;
    logic       lvl_q;
    assign pci_want[i] = ~(pci_stop_act & (~PCI_FREE_MASK[i] | pcif_stop_en));
    cgate_cell u_cell (
      .clk(clk), .rst_n(rst_n), .phase(pci_ph[i]), .oe(pci_oe[i]),
      .want_run(pci_want[i]), .mode(m), .run(pci_run[i]), .fall(pci_fall[i])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= se_level(m, pci_ph[i]);
    end
    assign pci_o[i] = lvl_q;
  end

endmodule

// File: rtl/cgate_chk.sv
module cgate_chk #(
  parameter int N_CPU = 3,
  parameter int N_SRC = 5,
  parameter int N_PCI = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CPU-1:0] cpu_oe,
  input logic [N_SRC-1:0] src_oe,
  input logic [N_PCI-1:0] pci_oe,
  input logic [N_CPU-1:0] cpu_t,
  input logic [N_CPU-1:0] cpu_c,
  input logic [N_SRC-1:0] src_t,
  input logic [N_SRC-1:0] src_c,
  input logic [N_PCI-1:0] pci_o,
  input logic [N_CPU-1:0] cpu_run,
  input logic [N_SRC-1:0] src_run,
  input logic [N_PCI-1:0] pci_run,
  input logic [N_CPU-1:0] cpu_fall,
  input logic [N_SRC-1:0] src_fall,
  input logic [N_PCI-1:0] pci_fall
);
  localparam int N_ALL = N_CPU + N_SRC + N_PCI;

  logic [N_ALL-1:0] all_run;
  logic [N_ALL-1:0] all_fall;
  assign all_run  = {pci_run, src_run, cpu_run};
  assign all_fall = {pci_fall, src_fall, cpu_fall};

  assert_cpu_off_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_t | cpu_c) & ~$past(cpu_oe)) == '0);

  assert_src_off_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_t | src_c) & ~$past(src_oe)) == '0);

  assert_pci_off_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_o & ~$past(pci_oe)) == '0);

  assert_pair_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_t & cpu_c) == '0) && ((src_t & src_c) == '0));

  assert_run_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((all_run ^ $past(all_run)) & ~$past(all_fall)) == '0);

  assert_cpu_park_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_oe) & ~cpu_run & ~(cpu_t & ~cpu_c)) == '0);

  assert_src_park_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_oe) & ~src_run & ~(src_t & ~src_c)) == '0);

  assert_pci_park_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_o & ~(pci_run & $past(pci_oe))) == '0);

endmodule

bind clk_stop_gate cgate_chk #(.N_CPU(N_CPU), .N_SRC(N_SRC), .N_PCI(N_PCI)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .cpu_oe(cpu_oe), .src_oe(src_oe), .pci_oe(pci_oe),
  .cpu_t(cpu_t), .cpu_c(cpu_c), .src_t(src_t), .src_c(src_c), .pci_o(pci_o),
  .cpu_run(cpu_run), .src_run(src_run), .pci_run(pci_run),
  .cpu_fall(cpu_fall), .src_fall(src_fall), .pci_fall(pci_fall)
);

// File: tb/clk_stop_gate_tb.sv
module clk_stop_gate_tb_top;
  localparam int N_CPU = 3;
  localparam int N_SRC = 5;
  localparam int N_PCI = 3;
  localparam int H_CPU = 2;
  localparam int H_SRC = 3;
  localparam int H_PCI = 4;
  localparam int N_OUT = N_CPU + N_SRC + N_PCI;
  localparam int SETTLE = 24;
  localparam int WINDOW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N_CPU-1:0] cpu_ph = '0, cpu_seen = '0;
  logic [N_SRC-1:0] src_ph = '0, src_seen = '0;
  logic [N_PCI-1:0] pci_ph = '0, pci_seen = '0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, cr_a_n = 1'b0, cr_c_n = 1'b0;
  logic [N_CPU-1:0] cpu_oe = '1, cpu_stop_en = '1;
  logic [N_SRC-1:0] src_oe = '1;
  logic [N_PCI-1:0] pci_oe = '1;
  logic src_stop_ctl = 1'b0, pcif_stop_en = 1'b0;
  logic cr_a_en = 1'b0, cr_a_sel = 1'b0, cr_c_en = 1'b0, cr_c_sel = 1'b0;
  logic [N_CPU-1:0] cpu_t, cpu_c;
  logic [N_SRC-1:0] src_t, src_c;
  logic [N_PCI-1:0] pci_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic glitch_en = 1'b0;
  int run_len [N_OUT];
  logic last_lv [N_OUT];
  logic [N_OUT-1:0] now_lv;

  clk_stop_gate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_ph(cpu_ph), .src_ph(src_ph), .pci_ph(pci_ph),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .cr_a_n(cr_a_n), .cr_c_n(cr_c_n),
    .cpu_oe(cpu_oe), .src_oe(src_oe), .pci_oe(pci_oe),
    .cpu_stop_en(cpu_stop_en), .src_stop_ctl(src_stop_ctl), .pcif_stop_en(pcif_stop_en),
    .cr_a_en(cr_a_en), .cr_a_sel(cr_a_sel), .cr_c_en(cr_c_en), .cr_c_sel(cr_c_sel),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .src_t(src_t), .src_c(src_c), .pci_o(pci_o)
  );

  function automatic int half_of(input int k);
    if (k < N_CPU) return H_CPU;
    if (k < N_CPU + N_SRC) return H_SRC;
    return H_PCI;
  endfunction

  // Source generation and runt monitor (R7), on the inactive edge.
  always @(negedge clk) begin
    now_lv = {pci_o, src_t, cpu_t};
    for (int k = 0; k < N_OUT; k++) begin
      if (!glitch_en) begin
        run_len[k] = 100;
        last_lv[k] = now_lv[k];
      end else if (now_lv[k] != last_lv[k]) begin
        n_chk++;
        if (run_len[k] < half_of(k)) begin
          n_fail++;
          $display("FAIL R7 output %0d level lasted actual %0d expected >= %0d", k, run_len[k], half_of(k));
        end
        run_len[k] = 1;
        last_lv[k] = now_lv[k];
      end else begin
        run_len[k]++;
      end
    end
    cpu_seen = cpu_ph;
    src_seen = src_ph;
    pci_seen = pci_ph;
    cyc++;
    for (int i = 0; i < N_CPU; i++) cpu_ph[i] = ((cyc + i) / H_CPU) % 2 == 1;
    for (int i = 0; i < N_SRC; i++) src_ph[i] = ((cyc + 2 * i) / H_SRC) % 2 == 1;
    for (int i = 0; i < N_PCI; i++) pci_ph[i] = ((cyc + i) / H_PCI) % 2 == 1;
  end

  // Bench model: 0 = off, 1 = parked, 2 = running.
  function automatic int cpu_mode(input int i);
    if (!cpu_oe[i]) return 0;                       // R1
    if (!cpu_stop_n && cpu_stop_en[i]) return 1;    // R2
    return 2;
  endfunction

  function automatic int pci_mode(input int i);
    if (!pci_oe[i]) return 0;
    if (!pci_stop_n && (i != 2 || pcif_stop_en)) return 1;   // R3
    return 2;
  endfunction

  function automatic bit req_hit(input logic en, input logic sel, input logic rq_n, input int i);
    return en && rq_n && (i == (sel ? 2 : 0));
  endfunction

  function automatic int src_mode(input int i);
    if (!src_oe[i]) return 0;
    if ((src_stop_ctl && !pci_stop_n) || req_hit(cr_a_en, cr_a_sel, cr_a_n, i)
        || req_hit(cr_c_en, cr_c_sel, cr_c_n, i)) return 1;   // R4 R5 R6 R8
    return 2;
  endfunction

  task automatic chk_pair(input string tag, input string nm, input int i, input int m,
                          input logic ph, input logic t, input logic c);
    logic [1:0] e;
    e = (m == 2) ? {ph, ~ph} : (m == 1) ? 2'b10 : 2'b00;
    n_chk++;
    if ({t, c} !== e) begin
      n_fail++;
      $display("FAIL %s %s%0d actual %b expected %b", tag, nm, i, {t, c}, e);
    end
  endtask

  task automatic chk_se(input string tag, input int i, input int m, input logic ph, input logic o);
    logic e;
    e = (m == 2) ? ph : 1'b0;
    n_chk++;
    if (o !== e) begin
      n_fail++;
      $display("FAIL %s pci%0d actual %b expected %b", tag, i, o, e);
    end
  endtask

  task automatic check_all(input string tag);
    repeat (SETTLE) @(negedge clk);
    for (int n = 0; n < WINDOW; n++) begin
      @(negedge clk);
      #1;
      for (int i = 0; i < N_CPU; i++) chk_pair(tag, "cpu", i, cpu_mode(i), cpu_seen[i], cpu_t[i], cpu_c[i]);
      for (int i = 0; i < N_SRC; i++) chk_pair(tag, "src", i, src_mode(i), src_seen[i], src_t[i], src_c[i]);
      for (int i = 0; i < N_PCI; i++) chk_se(tag, i, pci_mode(i), pci_seen[i], pci_o[i]);
    end
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    #1;
    n_chk++;
    if ({cpu_t, cpu_c, src_t, src_c, pci_o} !== '0) begin
      n_fail++;
      $display("FAIL R10 reset outputs actual %b expected 0", {cpu_t, cpu_c, src_t, src_c, pci_o});
    end
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R10 R9 run after reset");
    glitch_en = 1'b1;
  endtask

  task automatic t_cpu_stop;
    @(negedge clk);
    glitch_en = 1'b0;
    cpu_stop_en = 3'b101;
    repeat (4) @(negedge clk);
    glitch_en = 1'b1;
    cpu_stop_n = 1'b0;
    check_all("R2 cpu stop");
    cpu_stop_n = 1'b1;
    check_all("R2 R7 cpu release");
  endtask

  task automatic t_pci_stop;
    @(negedge clk);
    pci_stop_n = 1'b0;
    check_all("R3 R4 pci stop, src free");
    glitch_en = 1'b0;
    pcif_stop_en = 1'b1;
    repeat (4) @(negedge clk);
    glitch_en = 1'b1;
    check_all("R3 free output stoppable");
    glitch_en = 1'b0;
    src_stop_ctl = 1'b1;
    repeat (4) @(negedge clk);
    glitch_en = 1'b1;
    check_all("R4 src stop with pci");
    pci_stop_n = 1'b1;
    check_all("R4 R7 pci release");
  endtask

  task automatic t_req_a;
    @(negedge clk);
    cr_a_n = 1'b1;
    check_all("R5 request ignored while unrouted");
    glitch_en = 1'b0;
    cr_a_en = 1'b1;
    cr_a_sel = 1'b0;
    repeat (4) @(negedge clk);
    glitch_en = 1'b1;
    check_all("R5 request to src0");
    glitch_en = 1'b0;
    cr_a_sel = 1'b1;
    repeat (4) @(negedge clk);
    glitch_en = 1'b1;
    check_all("R5 request to src2");
    cr_a_n = 1'b0;
    check_all("R5 request low runs");
  endtask

  task automatic t_req_c;
    @(negedge clk);
    glitch_en = 1'b0;
    cr_c_en = 1'b1;
    cr_c_sel = 1'b0;
    repeat (4) @(negedge clk);
    glitch_en = 1'b1;
    cr_c_n = 1'b1;
    check_all("R6 request C to src0");
    glitch_en = 1'b0;
    cr_c_sel = 1'b1;
    repeat (4) @(negedge clk);
    glitch_en = 1'b1;
    check_all("R6 request C to src2");
    cr_c_n = 1'b0;
    cr_a_n = 1'b1;
    check_all("R8 either request parks src2");
    pci_stop_n = 1'b0;
    check_all("R8 stop plus request parks");
    pci_stop_n = 1'b1;
    cr_a_n = 1'b0;
    check_all("R6 all released");
  endtask

  task automatic t_disable;
    @(negedge clk);
    glitch_en = 1'b0;
    cpu_oe = 3'b101;
    src_oe = 5'b11011;
    pci_oe = 3'b110;
    cpu_stop_n = 1'b0;
    check_all("R1 R8 disable overrides stop");
    cpu_oe = 3'b000;
    src_oe = '0;
    pci_oe = '0;
    check_all("R1 all disabled");
    cpu_stop_n = 1'b1;
    cpu_oe = '1;
    src_oe = '1;
    pci_oe = '1;
    check_all("R1 R9 re-enabled");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_cpu_stop();
        t_pci_stop();
        t_req_a();
        t_req_c();
        t_disable();
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule